// File: doc/BRIEF.md
# Burst Readout Sequencer

This block frames readout into beam bursts. It runs on the 40 MHz machine clock and receives two kinds of already-decoded broadcast input: a special-command strobe that selects start or end of burst, and a trigger strobe that carries a 2-bit type. Each burst edge is a split pair. The command acts on the timestamp, and the trigger that follows decides whether data may flow.

A free-running timestamp counter is cleared by the start command. Data may be sent only after the start trigger has opened the window. Each physics or calibration trigger inside the window produces a one-cycle send strobe that carries the trigger type and the timestamp of the trigger cycle. The end command freezes the timestamp into a holding register. The end trigger then emits a one-cycle summary record that holds the frozen timestamp and the number of triggers served, and the block returns to idle.

Triggers that arrive outside the window are counted as errors. A start command that arrives in the middle of a burst restarts the sequence and raises a sticky sequence error. A counter rollover inside a burst raises a wrap flag.

Top module: `burst_readout_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block goes to `state`=0 (idle). `timestamp`, `oow_count`, `send_valid`, `eob_valid`, `seq_err` and `wrap_flag` all become 0.
- R2: On every clock that does not clear it, `timestamp` advances by one. It rolls over from 2^TS_W-1 to 0 with no other effect on the outputs.
- R3: A command (`cmd_valid`=1, `cmd_eob`=0) clears `timestamp`, so it reads 0 in the cycle after the command, and moves `state` to 1 (armed) from any state.
- R4: A trigger of type 2'b00 in armed moves `state` to 2 (taking), clears the served count and clears `wrap_flag`. In any other state it has no effect.
- R5: A trigger of type 2'b10 (physics) or 2'b11 (calibration) while taking asserts `send_valid` for one cycle, starting in the next cycle. `send_type` then holds the trigger type and `send_ts` holds the timestamp of the trigger cycle. The served count rises by one and saturates at 2^CNT_W-1.
- R6: A physics or calibration trigger in any state other than taking gives no `send_valid`. It raises `oow_count` by one, saturating at 2^ERR_W-1, and only reset lowers it.
- R7: A command with `cmd_eob`=1 while taking stores the current timestamp and moves `state` to 3 (ending). In any other state it has no effect.
- R8: A trigger of type 2'b01 while ending asserts `eob_valid` for one cycle in the next cycle, with `eob_ts` set to the stored timestamp and `eob_count` set to the served count, and moves `state` to 0. In any other state it has no effect.
- R9: A start command while taking or ending sets `seq_err`, which stays set until reset. The block still restarts: `state` goes to 1 and `timestamp` to 0.
- R10: A timestamp rollover while taking or ending sets `wrap_flag`. The flag stays set until the next accepted start trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz machine clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Special-command strobe |
| cmd_eob | input | 1 | Command select: 0 start, 1 end |
| trig_valid | input | 1 | Trigger strobe |
| trig_type | input | 2 | 00 start, 01 end, 10 physics, 11 calibration |
| timestamp | output | TS_W | Running timestamp |
| send_valid | output | 1 | One-cycle send strobe per served trigger |
| send_type | output | 2 | Type of the served trigger |
| send_ts | output | TS_W | Timestamp of the served trigger |
| eob_valid | output | 1 | One-cycle end-of-burst record strobe |
| eob_ts | output | TS_W | Timestamp stored by the end command |
| eob_count | output | CNT_W | Triggers served in the burst |
| oow_count | output | ERR_W | Sticky count of triggers outside the window |
| state | output | 2 | 0 idle, 1 armed, 2 taking, 3 ending |
| seq_err | output | 1 | Sticky sequence error |
| wrap_flag | output | 1 | Timestamp rolled over during a burst |

## Verification
Each trigger and command kind is applied in every state. This separates events that are accepted from those that are ignored or counted as out-of-window. One complete burst checks that the send timestamp, the frozen end timestamp and the served count each match the value seen at the input side in the right cycle. Long runs of triggers push both counters into saturation. A mid-burst start command and a rollover inside a burst show the restart path and the wrap flag, apart from normal sequencing.

// File: rtl/brs_pkg.sv
// Shared encodings for the burst readout sequencer.
package brs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_TAKING = 2'd2,
        ST_ENDING = 2'd3
    } brs_state_e;

    localparam logic [1:0] TRG_SOB   = 2'b00;
    localparam logic [1:0] TRG_EOB   = 2'b01;
    localparam logic [1:0] TRG_PHYS  = 2'b10;
    localparam logic [1:0] TRG_CALIB = 2'b11;
endpackage

// File: rtl/brs_timestamp.sv
// Free-running timestamp counter.
// Assumes: clr comes from a decoded start command. Rollover is silent.
// wrap_o marks the cycle in which the counter rolls back to zero.
module brs_timestamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [TS_W-1:0] ts_o,
    output logic            wrap_o
);
    localparam logic [TS_W-1:0] TS_MAX = '1;

    logic [TS_W-1:0] ts_q;

    // Count one per clock; a start command clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n)   ts_q <= '0;
        else if (clr) ts_q <= '0;
        else          ts_q <= ts_q + 1'b1;
    end

    assign ts_o   = ts_q;
    assign wrap_o = !clr && (ts_q == TS_MAX);

    AST_TS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ts_q == '0);                                   // R3
    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ts_q == $past(ts_q) + 1'b1);                  // R2
endmodule

// File: rtl/brs_control.sv
// Burst state machine and sticky flags.
// Assumes: at most one trigger and one command per cycle. When both
// arrive together, the trigger is judged against the current state and
// the command decides the next state.
module brs_control
    import brs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_eob,
    input  logic       trig_valid,
    input  logic [1:0] trig_type,
    input  logic       wrap_evt,
    output logic [1:0] state_o,
    output logic       ts_clr,
    output logic       ts_latch,
    output logic       open_burst,
    output logic       serve,
    output logic       drop,
    output logic       close,
    output logic       seq_err_o,
    output logic       wrap_flag_o
);
    brs_state_e st_q, st_d;
    logic       seq_err_q, wrap_q;
    logic       cmd_sob, cmd_end, trg_sob, trg_eob, trg_norm, in_burst;

    // Decode the incoming strobes.
    always_comb begin
        cmd_sob  = cmd_valid && !cmd_eob;
        cmd_end  = cmd_valid &&  cmd_eob;
        trg_sob  = trig_valid && (trig_type == TRG_SOB);
        trg_eob  = trig_valid && (trig_type == TRG_EOB);
        trg_norm = trig_valid && trig_type[1];
        in_burst = (st_q == ST_TAKING) || (st_q == ST_ENDING);
    end

    // Events accepted in the present state.
    always_comb begin
        ts_clr     = cmd_sob;
        ts_latch   = cmd_end  && (st_q == ST_TAKING);
        open_burst = trg_sob  && (st_q == ST_ARMED);
        serve      = trg_norm && (st_q == ST_TAKING);
        drop       = trg_norm && (st_q != ST_TAKING);
        close      = trg_eob  && (st_q == ST_ENDING);
    end

    // Next state; the start command takes priority.
    always_comb begin
        st_d = st_q;
        if (cmd_sob)         st_d = ST_ARMED;
        else if (ts_latch)   st_d = ST_ENDING;
        else if (open_burst) st_d = ST_TAKING;
        else if (close)      st_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sticky sequence error for a start command in mid-burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                   seq_err_q <= 1'b0;
        else if (cmd_sob && in_burst) seq_err_q <= 1'b1;
    end

    // Wrap flag: set by a rollover during a burst, cleared by the next opening.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wrap_q <= 1'b0;
        else if (wrap_evt && in_burst) wrap_q <= 1'b1;
        else if (open_burst)           wrap_q <= 1'b0;
    end

    assign state_o     = st_q;
    assign seq_err_o   = seq_err_q;
    assign wrap_flag_o = wrap_q;

    AST_SEQERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_q |=> seq_err_q);                              // R9
    AST_CLOSE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !cmd_sob) |=> st_q == ST_IDLE);              // R8
    AST_RESTART_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sob |=> st_q == ST_ARMED);                         // R3
endmodule

// File: rtl/brs_tally.sv
// Served-trigger and error counters, send strobe and end-of-burst record.
// Assumes: serve, drop, close and open_burst are one-cycle pulses from the
// control FSM, and at most one of serve, drop, close is high per cycle.
module brs_tally #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  ts,
    input  logic [1:0]       trig_type,
    input  logic             serve,
    input  logic             drop,
    input  logic             ts_latch,
    input  logic             open_burst,
    input  logic             close,
    output logic             send_valid,
    output logic [1:0]       send_type,
    output logic [TS_W-1:0]  send_ts,
    output logic             eob_valid,
    output logic [TS_W-1:0]  eob_ts,
    output logic [CNT_W-1:0] eob_count,
    output logic [ERR_W-1:0] oow_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic [CNT_W-1:0] served_q;
    logic [ERR_W-1:0] oow_q;
    logic [TS_W-1:0]  hold_q;

    // Saturating count of triggers served in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                            served_q <= '0;
        else if (open_burst)                   served_q <= '0;
        else if (serve && served_q != CNT_MAX) served_q <= served_q + 1'b1;
    end

    // Saturating, sticky count of triggers outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                        oow_q <= '0;
        else if (drop && oow_q != ERR_MAX) oow_q <= oow_q + 1'b1;
    end

    // Holding register for the timestamp at the end command.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (ts_latch) hold_q <= ts;
    end

    // One-cycle send strobe with the type and timestamp of the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_valid <= 1'b0;
            send_type  <= '0;
            send_ts    <= '0;
        end else begin
            send_valid <= serve;
            if (serve) begin
                send_type <= trig_type;
                send_ts   <= ts;
            end
        end
    end

    // One-cycle end-of-burst record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eob_valid <= 1'b0;
            eob_ts    <= '0;
            eob_count <= '0;
        end else begin
            eob_valid <= close;
            if (close) begin
                eob_ts    <= hold_q;
                eob_count <= served_q;
            end
        end
    end

    assign oow_count = oow_q;

    AST_OOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        oow_q != '0 |=> oow_q != '0);                          // R6
    AST_SERVED_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (served_q == CNT_MAX && !open_burst) |=> served_q == CNT_MAX); // R5
    AST_SEND_EOB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_valid && eob_valid));                           // R8
endmodule

// File: rtl/burst_readout_seq.sv
// Top of the burst readout sequencer.
// Assumes: the command and trigger strobes are already decoded and are
// synchronous to clk. The payload path is outside this block.
module burst_readout_seq #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_eob,
    input  logic             trig_valid,
    input  logic [1:0]       trig_type,
    output logic [TS_W-1:0]  timestamp,
    output logic             send_valid,
    output logic [1:0]       send_type,
    output logic [TS_W-1:0]  send_ts,
    output logic             eob_valid,
    output logic [TS_W-1:0]  eob_ts,
    output logic [CNT_W-1:0] eob_count,
    output logic [ERR_W-1:0] oow_count,
    output logic [1:0]       state,
    output logic             seq_err,
    output logic             wrap_flag
);
    logic ts_clr, wrap_evt, ts_latch, open_burst, serve, drop, close;

    brs_timestamp #(.TS_W(TS_W)) u_ts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ts_clr),
        .ts_o   (timestamp),
        .wrap_o (wrap_evt)
    );

    brs_control u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_eob     (cmd_eob),
        .trig_valid  (trig_valid),
        .trig_type   (trig_type),
        .wrap_evt    (wrap_evt),
        .state_o     (state),
        .ts_clr      (ts_clr),
        .ts_latch    (ts_latch),
        .open_burst  (open_burst),
        .serve       (serve),
        .drop        (drop),
        .close       (close),
        .seq_err_o   (seq_err),
        .wrap_flag_o (wrap_flag)
    );

    brs_tally #(.TS_W(TS_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts         (timestamp),
        .trig_type  (trig_type),
        .serve      (serve),
        .drop       (drop),
        .ts_latch   (ts_latch),
        .open_burst (open_burst),
        .close      (close),
        .send_valid (send_valid),
        .send_type  (send_type),
        .send_ts    (send_ts),
        .eob_valid  (eob_valid),
        .eob_ts     (eob_ts),
        .eob_count  (eob_count),
        .oow_count  (oow_count)
    );

    AST_SEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> $past(state) == 2'd2);                  // R5
    AST_RECORD_FROM_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
        eob_valid |-> $past(state) == 2'd3);                   // R8
endmodule

// File: tb/burst_readout_seq_tb.sv
// Directed bench for the burst readout sequencer. It uses narrow widths
// so that rollover and saturation are reached in a short run.
module burst_readout_seq_tb;
    localparam int TS_W  = 10;
    localparam int CNT_W = 4;
    localparam int ERR_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_eob = 1'b0;
    logic             trig_valid = 1'b0;
    logic [1:0]       trig_type = 2'b00;
    logic [TS_W-1:0]  timestamp;
    logic             send_valid;
    logic [1:0]       send_type;
    logic [TS_W-1:0]  send_ts;
    logic             eob_valid;
    logic [TS_W-1:0]  eob_ts;
    logic [CNT_W-1:0] eob_count;
    logic [ERR_W-1:0] oow_count;
    logic [1:0]       state;
    logic             seq_err;
    logic             wrap_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [TS_W-1:0] ts_seen;

    always #5 clk = ~clk;

    burst_readout_seq #(.TS_W(TS_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_eob(cmd_eob),
        .trig_valid(trig_valid), .trig_type(trig_type), .timestamp(timestamp),
        .send_valid(send_valid), .send_type(send_type), .send_ts(send_ts),
        .eob_valid(eob_valid), .eob_ts(eob_ts), .eob_count(eob_count),
        .oow_count(oow_count), .state(state), .seq_err(seq_err),
        .wrap_flag(wrap_flag)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue a command for one cycle; on return the edge that took it has passed.
    task automatic do_cmd(input logic eob);
        @(negedge clk);
        ts_seen   = timestamp;
        cmd_valid = 1'b1;
        cmd_eob   = eob;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_eob   = 1'b0;
    endtask

    task automatic do_trig(input logic [1:0] ty);
        @(negedge clk);
        ts_seen    = timestamp;
        trig_valid = 1'b1;
        trig_type  = ty;
        @(negedge clk);
        trig_valid = 1'b0;
        trig_type  = 2'b00;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        chk("R1 state", state, 0);
        chk("R1 timestamp", timestamp, 0);
        chk("R1 send_valid", send_valid, 0);
        chk("R1 eob_valid", eob_valid, 0);
        chk("R1 oow_count", oow_count, 0);
        chk("R1 seq_err", seq_err, 0);
        chk("R1 wrap_flag", wrap_flag, 0);
        idle(5);
        chk("R2 count step", timestamp, 5);
    endtask

    task automatic t_idle_ignored;
        do_trig(2'b10);
        chk("R6 no send in idle", send_valid, 0);
        chk("R6 oow counted", oow_count, 1);
        do_cmd(1'b1);
        chk("R7 end cmd ignored in idle", state, 0);
        do_trig(2'b01);
        chk("R8 end trig ignored: no record", eob_valid, 0);
        chk("R8 end trig ignored: state", state, 0);
        do_trig(2'b00);
        chk("R4 start trig ignored in idle", state, 0);
    endtask

    task automatic t_burst;
        logic [TS_W-1:0] frozen;
        do_cmd(1'b0);
        chk("R3 timestamp cleared", timestamp, 0);
        chk("R3 armed", state, 1);
        do_trig(2'b11);
        chk("R6 no send in armed", send_valid, 0);
        chk("R6 oow in armed", oow_count, 2);
        do_trig(2'b00);
        chk("R4 taking", state, 2);
        do_trig(2'b10);
        chk("R5 send strobe", send_valid, 1);
        chk("R5 physics type", send_type, 2);
        chk("R5 send ts", send_ts, ts_seen);
        idle(1);
        chk("R5 strobe one cycle", send_valid, 0);
        idle(4);
        do_trig(2'b11);
        chk("R5 calib type", send_type, 3);
        chk("R5 calib ts", send_ts, ts_seen);
        do_cmd(1'b1);
        frozen = ts_seen;
        chk("R7 ending", state, 3);
        idle(7);
        do_trig(2'b10);
        chk("R6 no send in ending", send_valid, 0);
        chk("R6 oow in ending", oow_count, 3);
        do_cmd(1'b1);
        chk("R7 end cmd ignored in ending", state, 3);
        do_trig(2'b01);
        chk("R8 record strobe", eob_valid, 1);
        chk("R8 record ts", eob_ts, frozen);
        chk("R8 record count", eob_count, 2);
        chk("R8 back to idle", state, 0);
        idle(1);
        chk("R8 record one cycle", eob_valid, 0);
    endtask

    task automatic t_oow_saturate;
        for (int i = 0; i < 6; i++) do_trig(2'b10);
        chk("R6 oow saturates", oow_count, 7);
    endtask

    task automatic t_served_saturate;
        do_cmd(1'b0);
        do_trig(2'b00);
        for (int i = 0; i < 20; i++) do_trig(2'b10);
        do_cmd(1'b1);
        do_trig(2'b01);
        chk("R5 served count saturates", eob_count, 15);
        chk("R9 no seq_err on clean bursts", seq_err, 0);
    endtask

    task automatic t_restart_and_wrap;
        logic [TS_W-1:0] ts_a;
        do_cmd(1'b0);
        do_trig(2'b00);
        idle(3);
        do_cmd(1'b0);
        chk("R9 seq_err set", seq_err, 1);
        chk("R9 restart armed", state, 1);
        chk("R9 restart ts", timestamp, 0);
        do_trig(2'b00);
        chk("R10 wrap clear at start", wrap_flag, 0);
        ts_a = timestamp;
        idle(1 << TS_W);
        chk("R2 silent rollover", timestamp, ts_a);
        chk("R10 wrap flag set", wrap_flag, 1);
        do_cmd(1'b1);
        do_trig(2'b01);
        chk("R8 record after wrap", eob_valid, 1);
        do_cmd(1'b0);
        chk("R10 wrap held before opening", wrap_flag, 1);
        chk("R9 seq_err sticky", seq_err, 1);
        do_trig(2'b00);
        chk("R10 wrap cleared by opening", wrap_flag, 0);
    endtask

    initial begin
        t_reset();
        t_idle_ignored();
        t_burst();
        t_oow_saturate();
        t_served_saturate();
        t_restart_and_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule